// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the register front end of a two-channel bus-master disk DMA controller. Software reaches it through a byte-addressed I/O port bus covering 16 bytes. Each channel owns an 8-byte window holding a command byte, a shared vendor mode byte, a status byte, a per-channel vendor timing byte and a 32-bit descriptor-table pointer. The pointer accepts byte, halfword and word accesses.

Each channel has a small state machine with two states. `CH_IDLE` moves to `CH_RUN` on transition GO: a command write with the enable bit set, which pulses `dma_start`. `CH_RUN` returns to `CH_IDLE` on transition STOP (a command write with the enable bit clear, which pulses `dma_cancel`) or on transition FINISH (the `xfer_done` input from the DMA engine). A STOP command in `CH_IDLE` still pulses `dma_cancel`. The channel interrupt lines are latched into pending bits of the vendor mode byte. Those bits, each gated by its own software block bit, form one merged interrupt output.

Top module: `busmaster_dma_regs`

## Requirements
- R1: Port address bit 3 selects the channel (0 at 0x0-0x7, 1 at 0x8-0xF). Within a window, offset 0 is command, 1 is vendor mode, 2 is status, 3 is vendor timing and 4-7 is the descriptor pointer. Byte registers read zero-extended on `io_rdata`.
- R2: A command write stores only bits 0 and 3 (mask 0x09). With bit 0 set in `CH_IDLE`, the channel enters `CH_RUN`: status bit 0 and `dma_active` are 1 and `dma_start` is high for exactly the one cycle after the write edge. A further bit-0 command write in `CH_RUN` gives no start pulse.
- R3: A command write with bit 0 clear gives a one-cycle `dma_cancel` pulse after the write edge and returns the channel to `CH_IDLE` (status bit 0 = 0).
- R4: A status write sets the new status to (data & 0x60) | (old & 0x01) | (old & ~data & 0x06). Bits 5-6 are read/write, bit 0 is kept, and bits 1-2 are cleared by writing 1.
- R5: A `xfer_done` pulse clears the active state and sets status bit 2. If a status write in the same cycle clears bit 2, bit 2 still ends at 1.
- R6: Pointer writes use `io_size` (0 = byte, 1 = halfword, 2 = word). Byte and halfword writes replace only the lanes at shift (offset & 3) × 8. Word writes replace all 32 bits. Bits 1:0 always become 0. Pointer reads return the value shifted right by the same amount and masked to the access width.
- R7: Every pointer write also loads the new value into `cur_addr0`/`cur_addr1`, visible after the write edge.
- R8: The vendor mode byte holds channel-0 pending at bit 2, channel-1 pending at bit 3, channel-0 block at bit 4 and channel-1 block at bit 5. Writes through either channel's offset 1 change only bits 4-5. Each pending bit follows its `chan_irq` line one clock later.
- R9: `irq_out` = (pend0 & ~blk0) | (pend1 & ~blk1), updated together with those bits.
- R10: Channel 0 offset 3 reads and writes timing byte A, and channel 1 offset 3 uses timing byte B.
- R11: With `VENDOR_EXT` = 0, offsets 1 and 3 read 0xFF, writes to them are ignored, and `irq_out` is pend0 | pend1.
- R12: While reset is asserted, `dma_cancel` is 2'b11 for both channels. After reset, command, status, pointer and current-address registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for the addressed port |
| io_addr | input | 4 | Port address within the 16-byte region |
| io_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| io_wdata | input | 32 | Write data, least significant lane first |
| io_rdata | output | 32 | Combinational read data for io_addr/io_size |
| chan_irq | input | 2 | Interrupt request level from each channel |
| xfer_done | input | 2 | Per-channel completion pulse from the DMA engine |
| dma_start | output | 2 | Per-channel one-cycle start pulse |
| dma_cancel | output | 2 | Per-channel one-cycle cancel pulse |
| dma_active | output | 2 | Per-channel active flag (status bit 0) |
| cur_addr0 | output | 32 | Current descriptor address, channel 0 |
| cur_addr1 | output | 32 | Current descriptor address, channel 1 |
| irq_out | output | 1 | Merged, maskable interrupt |

## Verification
Reads are combinational, so a register value can be sampled in the cycle after the write edge that changed it. `dma_start` and `dma_cancel` are due in the one cycle that follows the write edge and are gone one edge later. Pending bits, and `irq_out` with them, follow `chan_irq` one edge after the line changes. The bench drives inputs at falling edges, and every expected item it queues is sampled shortly after the next falling edge. Each result is therefore observed exactly in the cycle it is due.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;

    localparam int PTR_W    = 32;
    localparam int NUM_CH   = 2;
    localparam int WIN_BITS = 3;
    localparam logic [7:0] CMD_KEEP = 8'h09;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    function automatic logic [PTR_W-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
        logic [PTR_W-1:0] m;
        unique case (sz)
            SZ_BYTE: m = 32'h0000_00FF << {off, 3'b000};
            SZ_HALF: m = 32'h0000_FFFF << {off, 3'b000};
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_merge(input logic [PTR_W-1:0] old,
                                                   input logic [PTR_W-1:0] wd,
                                                   input logic [1:0] sz,
                                                   input logic [1:0] off);
        logic [PTR_W-1:0] m;
        logic [PTR_W-1:0] sh;
        m  = lane_mask(sz, off);
        sh = (sz == SZ_BYTE || sz == SZ_HALF) ? (wd << {off, 3'b000}) : wd;
        return ((old & ~m) | (sh & m)) & ~32'h3;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_extract(input logic [PTR_W-1:0] p,
                                                     input logic [1:0] sz,
                                                     input logic [1:0] off);
        logic [PTR_W-1:0] v;
        unique case (sz)
            SZ_BYTE: v = (p >> {off, 3'b000}) & 32'h0000_00FF;
            SZ_HALF: v = (p >> {off, 3'b000}) & 32'h0000_FFFF;
            default: v = p;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmaregs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic             stat_we,
    input  logic             ptr_we,
    input  logic             done,
    input  logic [7:0]       wbyte,
    input  logic [PTR_W-1:0] wword,
    input  logic [1:0]       wsize,
    input  logic [1:0]       woff,
    output logic [7:0]       cmd_q,
    output logic [7:0]       stat_byte,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] cur_q,
    output logic             start_o,
    output logic             cancel_o,
    output logic             active_o
);

    ch_state_e  state_q, state_d;
    logic       go, stop;
    logic       stat_int, stat_err;
    logic [1:0] stat_rw;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // transitions GO, STOP, FINISH
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        stop    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (cmd_we && wbyte[0]) begin
                    state_d = CH_RUN;
                    go      = 1'b1;
                end else if (cmd_we) begin
                    stop = 1'b1;
                end
            end
            CH_RUN: begin
                if (cmd_we && !wbyte[0]) begin
                    state_d = CH_IDLE;
                    stop    = 1'b1;
                end else if (done) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // registered pulse outputs; cancel held high through reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            cancel_o <= 1'b1;
        end else begin
            start_o  <= go;
            cancel_o <= stop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            stat_int <= 1'b0;
            stat_err <= 1'b0;
            stat_rw  <= '0;
            ptr_q    <= '0;
            cur_q    <= '0;
        end else begin
            if (cmd_we) cmd_q <= wbyte & CMD_KEEP;
            if (stat_we) begin
                stat_rw <= wbyte[6:5];
                if (wbyte[1]) stat_err <= 1'b0;
                if (wbyte[2]) stat_int <= 1'b0;
            end
            if (done) stat_int <= 1'b1;
            if (ptr_we) begin
                ptr_q <= ptr_merge(ptr_q, wword, wsize, woff);
                cur_q <= ptr_merge(ptr_q, wword, wsize, woff);
            end
        end
    end

    assign active_o  = (state_q == CH_RUN);
    assign stat_byte = {1'b0, stat_rw, 2'b00, stat_int, stat_err, active_o};

    // R2
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R2
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> active_o);
    // R3
    no_start_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && cancel_o));
    // R5
    int_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_int) |-> $past(done));
    // R7
    cur_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ptr_we)) |-> (cur_q == ptr_q));

endmodule

// File: rtl/dma_vendor_regs.sv
module dma_vendor_regs
    import dmaregs_pkg::*;
#(
    parameter bit VENDOR_EXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [NUM_CH-1:0] tim_we,
    input  logic [7:0]        wbyte,
    input  logic [NUM_CH-1:0] chan_irq,
    output logic [7:0]        mode_byte,
    output logic [NUM_CH-1:0][7:0] tim_q,
    output logic              irq_out
);

    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] blk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= chan_irq;
    end

    generate
        if (VENDOR_EXT) begin : g_ext
            always_ff @(posedge clk) begin
                if (!rst_n)       blk_q <= '0;
                else if (mode_we) blk_q <= wbyte[5:4];
            end
            for (genvar g = 0; g < NUM_CH; g++) begin : g_tim
                always_ff @(posedge clk) begin
                    if (!rst_n)         tim_q[g] <= '0;
                    else if (tim_we[g]) tim_q[g] <= wbyte;
                end
            end
        end else begin : g_noext
            assign blk_q = '0;
            assign tim_q = '0;
        end
    endgenerate

    assign mode_byte = {2'b00, blk_q, pend_q, 2'b00};
    assign irq_out   = |(pend_q & ~blk_q);

    // R9
    all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q == 2'b11) |-> !irq_out);
    // R8
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q == $past(chan_irq)));

endmodule

// File: rtl/busmaster_dma_regs.sv
module busmaster_dma_regs
    import dmaregs_pkg::*;
#(
    parameter bit VENDOR_EXT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic [3:0]  io_addr,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    input  logic [1:0]  chan_irq,
    input  logic [1:0]  xfer_done,
    output logic [1:0]  dma_start,
    output logic [1:0]  dma_cancel,
    output logic [1:0]  dma_active,
    output logic [31:0] cur_addr0,
    output logic [31:0] cur_addr1,
    output logic        irq_out
);

    logic                    sel;
    logic [WIN_BITS-1:0]     off;
    logic [NUM_CH-1:0][7:0]  cmd_b, stat_b, tim_b;
    logic [NUM_CH-1:0][PTR_W-1:0] ptr_v, cur_v;
    logic [NUM_CH-1:0]       tim_we;
    logic [7:0]              mode_b;
    logic                    mode_we;

    assign sel = io_addr[3];
    assign off = io_addr[WIN_BITS-1:0];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic hit;
            assign hit       = io_wr && (sel == g[0]);
            assign tim_we[g] = hit && (off == 3'd3) && VENDOR_EXT;
            dma_chan_regs u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cmd_we   (hit && (off == 3'd0)),
                .stat_we  (hit && (off == 3'd2)),
                .ptr_we   (hit && off[2]),
                .done     (xfer_done[g]),
                .wbyte    (io_wdata[7:0]),
                .wword    (io_wdata),
                .wsize    (io_size),
                .woff     (off[1:0]),
                .cmd_q    (cmd_b[g]),
                .stat_byte(stat_b[g]),
                .ptr_q    (ptr_v[g]),
                .cur_q    (cur_v[g]),
                .start_o  (dma_start[g]),
                .cancel_o (dma_cancel[g]),
                .active_o (dma_active[g])
            );
        end
    endgenerate

    assign mode_we = io_wr && (off == 3'd1) && VENDOR_EXT;

    dma_vendor_regs #(.VENDOR_EXT(VENDOR_EXT)) u_vnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (mode_we),
        .tim_we   (tim_we),
        .wbyte    (io_wdata[7:0]),
        .chan_irq (chan_irq),
        .mode_byte(mode_b),
        .tim_q    (tim_b),
        .irq_out  (irq_out)
    );

    always_comb begin
        io_rdata = '0;
        unique case (off)
            3'd0: io_rdata = {24'h0, cmd_b[sel]};
            3'd1: io_rdata = {24'h0, (VENDOR_EXT ? mode_b : 8'hFF)};
            3'd2: io_rdata = {24'h0, stat_b[sel]};
            3'd3: io_rdata = {24'h0, (VENDOR_EXT ? tim_b[sel] : 8'hFF)};
            default: io_rdata = ptr_extract(ptr_v[sel], io_size, off[1:0]);
        endcase
    end

    assign cur_addr0 = cur_v[0];
    assign cur_addr1 = cur_v[1];

    // R12
    reset_cancel_chk: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (dma_cancel == 2'b11));
    // R6
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off[2] && io_size == 2'b10) |-> (io_rdata[1:0] == 2'b00));

endmodule

// File: tb/sim_busmaster_dma_regs.sv
module sim_busmaster_dma_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [1:0]  chan_irq = '0;
    logic [1:0]  xfer_done = '0;
    logic [31:0] rdata0, rdata1, cur0, cur1, cur0b, cur1b;
    logic [1:0]  start0, cancel0, active0, start1, cancel1, active1;
    logic        irq0, irq1;

    always #(CLK_PERIOD/2) clk = ~clk;

    busmaster_dma_regs #(.VENDOR_EXT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(rdata0), .chan_irq(chan_irq), .xfer_done(xfer_done),
        .dma_start(start0), .dma_cancel(cancel0), .dma_active(active0),
        .cur_addr0(cur0), .cur_addr1(cur1), .irq_out(irq0));

    busmaster_dma_regs #(.VENDOR_EXT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(rdata1), .chan_irq(chan_irq), .xfer_done(xfer_done),
        .dma_start(start1), .dma_cancel(cancel1), .dma_active(active1),
        .cur_addr0(cur0b), .cur_addr1(cur1b), .irq_out(irq1));

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t q[$];
    event      mon_ev;
    int        n_checks = 0;
    int        n_fail   = 0;
    bit        finished = 0;

    localparam int K_RD0 = 0, K_START = 1, K_CANCEL = 2, K_ACTIVE = 3, K_IRQ0 = 4,
                   K_CUR0 = 5, K_CUR1 = 6, K_RD1 = 7, K_IRQ1 = 8;

    function automatic logic [31:0] observe(int kind);
        case (kind)
            K_RD0:    return rdata0;
            K_START:  return {30'h0, start0};
            K_CANCEL: return {30'h0, cancel0};
            K_ACTIVE: return {30'h0, active0};
            K_IRQ0:   return {31'h0, irq0};
            K_CUR0:   return cur0;
            K_CUR1:   return cur1;
            K_RD1:    return rdata1;
            default:  return {31'h0, irq1};
        endcase
    endfunction

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = observe(it.kind);
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_at(input int kind, input logic [3:0] a, input logic [1:0] s,
                             input logic [31:0] e, input string tag);
        exp_item_t it;
        io_addr = a;
        io_size = s;
        #1;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        q.push_back(it);
        ->mon_ev;
        wait (q.size() == 0);
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, input logic [31:0] e, input string tag);
        expect_at(K_RD0, a, s, e, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_size = s; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R12 reset behaviour
        repeat (3) tick();
        expect_at(K_CANCEL, 4'h0, 2'd0, 32'h3, "R12 cancel during reset");
        rst_n = 1'b1;
        tick();
        expect_at(K_CANCEL, 4'h0, 2'd0, 32'h0, "R12 cancel after reset");
        rd(4'h0, 2'd0, 32'h0, "R12 cmd reset");
        rd(4'hA, 2'd0, 32'h0, "R12 status ch1 reset");
        rd(4'h4, 2'd2, 32'h0, "R12 ptr reset");

        // R2 start
        wr(4'h0, 2'd0, 32'hFF);
        expect_at(K_START, 4'h0, 2'd0, 32'h1, "R2 start pulse");
        rd(4'h0, 2'd0, 32'h09, "R2 cmd mask");
        rd(4'h2, 2'd0, 32'h01, "R1 R2 status active");
        expect_at(K_ACTIVE, 4'h0, 2'd0, 32'h1, "R2 active flag");
        tick();
        expect_at(K_START, 4'h0, 2'd0, 32'h0, "R2 pulse one cycle");
        wr(4'h0, 2'd0, 32'h01);
        expect_at(K_START, 4'h0, 2'd0, 32'h0, "R2 no restart while active");

        // R5 completion
        @(negedge clk); xfer_done = 2'b01;
        @(negedge clk); xfer_done = 2'b00;
        rd(4'h2, 2'd0, 32'h04, "R5 done sets bit2 clears active");

        // R4 status rule
        wr(4'h2, 2'd0, 32'h66);
        rd(4'h2, 2'd0, 32'h60, "R4 w1c and rw bits");
        wr(4'h2, 2'd0, 32'h00);
        rd(4'h2, 2'd0, 32'h00, "R4 rw bits cleared");

        // channel 1, R4 preserve, R3 cancel
        wr(4'h8, 2'd0, 32'h01);
        expect_at(K_START, 4'h0, 2'd0, 32'h2, "R1 R2 start ch1");
        wr(4'hA, 2'd0, 32'h07);
        rd(4'hA, 2'd0, 32'h01, "R4 bit0 preserved");
        wr(4'h8, 2'd0, 32'h08);
        expect_at(K_CANCEL, 4'h0, 2'd0, 32'h2, "R3 cancel ch1");
        expect_at(K_ACTIVE, 4'h0, 2'd0, 32'h0, "R3 active cleared");
        rd(4'h8, 2'd0, 32'h08, "R2 cmd ch1 bit3");
        rd(4'hA, 2'd0, 32'h00, "R3 status ch1 idle");

        // R5 same-cycle priority
        wr(4'h0, 2'd0, 32'h01);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 4'h2; io_size = 2'd0; io_wdata = 32'h04; xfer_done = 2'b01;
        @(negedge clk);
        io_wr = 1'b0; xfer_done = 2'b00;
        rd(4'h2, 2'd0, 32'h04, "R5 set wins over w1c");
        expect_at(K_ACTIVE, 4'h0, 2'd0, 32'h0, "R5 active dropped");

        // R6 R7 pointer
        wr(4'h4, 2'd2, 32'h12345677);
        rd(4'h4, 2'd2, 32'h12345674, "R6 word write aligned");
        expect_at(K_CUR0, 4'h0, 2'd0, 32'h12345674, "R7 cur copy word");
        wr(4'h5, 2'd0, 32'h000000AB);
        rd(4'h4, 2'd2, 32'h1234AB74, "R6 byte lane 1");
        rd(4'h5, 2'd0, 32'h000000AB, "R6 byte read lane 1");
        wr(4'h6, 2'd1, 32'h0000BEEF);
        rd(4'h4, 2'd2, 32'hBEEFAB74, "R6 half upper");
        rd(4'h6, 2'd1, 32'h0000BEEF, "R6 half read");
        wr(4'h4, 2'd0, 32'h000000FF);
        expect_at(K_CUR0, 4'h0, 2'd0, 32'hBEEFABFC, "R6 R7 byte lane 0 aligned");
        rd(4'hC, 2'd2, 32'h0, "R1 ch1 ptr untouched");
        wr(4'hD, 2'd1, 32'h00001234);
        expect_at(K_CUR1, 4'h0, 2'd0, 32'h00123400, "R7 cur ch1 half lane 1");

        // R8 R9 R11 interrupt merge
        @(negedge clk); chan_irq = 2'b01;
        tick();
        expect_at(K_IRQ0, 4'h0, 2'd0, 32'h1, "R9 irq pend0");
        rd(4'h1, 2'd0, 32'h04, "R8 pend0 bit");
        expect_at(K_RD1, 4'h1, 2'd0, 32'hFF, "R11 mode reads FF");
        wr(4'h1, 2'd0, 32'h3F);
        rd(4'h1, 2'd0, 32'h34, "R8 only block bits written");
        expect_at(K_IRQ0, 4'h0, 2'd0, 32'h0, "R9 irq blocked");
        expect_at(K_IRQ1, 4'h0, 2'd0, 32'h1, "R11 block write ignored");
        @(negedge clk); chan_irq = 2'b11;
        tick();
        rd(4'h1, 2'd0, 32'h3C, "R8 pend1 bit");
        expect_at(K_IRQ0, 4'h0, 2'd0, 32'h0, "R9 both blocked");
        wr(4'h9, 2'd0, 32'h20);
        rd(4'h9, 2'd0, 32'h2C, "R8 shared via ch1");
        expect_at(K_IRQ0, 4'h0, 2'd0, 32'h1, "R9 pend0 unblocked");
        @(negedge clk); chan_irq = 2'b00;
        tick();
        expect_at(K_IRQ0, 4'h0, 2'd0, 32'h0, "R9 lines low");

        // R10 timing
        wr(4'h3, 2'd0, 32'h5A);
        wr(4'hB, 2'd0, 32'hC3);
        rd(4'h3, 2'd0, 32'h5A, "R10 timing A");
        rd(4'hB, 2'd0, 32'hC3, "R10 timing B");
        expect_at(K_RD1, 4'h3, 2'd0, 32'hFF, "R11 timing reads FF");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule